// File: doc/BRIEF.md
# Logical and Arithmetic Shift Unit

This block shifts a data word by a constant amount held in a small field. It can shift left with zero fill, shift right with zero fill, or shift right while copying the sign bit into the vacated high positions. It is purely combinational. The result settles within the same cycle as its inputs, so the block can sit beside the ALU of a single-cycle integer datapath and share its result multiplexer.

The shift runs through a chain of logarithmic stages. The first stage moves the word by half its width and each later stage moves it by half as much as the one before. Each stage is enabled by one bit of the shift amount. A single control slice sets the direction and the fill bit for the whole chain. One operation code passes the operand through unchanged, so that code never reaches the stages.

Top module: `log_shifter`

## Requirements
- R1: With op code 2'b00 (left logical), result bit i equals operand bit i-amt for i >= amt, and the amt low bits are 0.
- R2: With op code 2'b10 (right logical), result bit i equals operand bit i+amt for i+amt < WIDTH, and the amt high bits are 0.
- R3: With op code 2'b11 (right arithmetic), the shifted bits match R2, and the amt high bits are copies of the operand's original top bit.
- R4: With op code 2'b01, the result equals the operand for every shift amount.
- R5: A shift amount of 0 returns the operand unchanged for every op code.
- R6: With WIDTH=32, shifting 0x12345678 by 8 gives 0x34567800 when shifting left, and 0x00123456 for both right shifts. Shifting 0x92345678 right arithmetically by 8 gives 0xFF923456.
- R7: At the largest amount (WIDTH-1), a left shift leaves only the operand's bit 0, placed in the top bit. A right logical shift leaves only the operand's top bit, placed in bit 0. A right arithmetic shift gives all ones or all zeros, following the operand's top bit.
- R8: The result follows any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH | Word to be shifted |
| amt_i | input | $clog2(WIDTH) | Shift amount, 0 to WIDTH-1 |
| op_i | input | 2 | Operation select: 00 left logical, 01 pass, 10 right logical, 11 right arithmetic |
| res_o | output | WIDTH | Shifted word |

## Verification
The bench builds the unit with its default WIDTH of 32, which gives a 5-bit amount and five stages. At this size every shift amount from 0 to 31 can be swept for every op code against a bit-by-bit model computed in the bench. The sweep uses operands with the top bit set and with it clear. This reaches every combination of enabled stages, the fill bit under both sign values, and both amount extremes.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LL   = 2'b00,
    SH_PASS = 2'b01,
    SH_RL   = 2'b10,
    SH_RA   = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_ctl.sv
module shift_ctl
  import shift_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       msb_i,
  output logic       active_o,
  output logic       right_o,
  output logic       fill_o
);
  shift_op_e op;

  always_comb begin
    op       = shift_op_e'(op_i);
    active_o = (op != SH_PASS);
    right_o  = (op == SH_RL) || (op == SH_RA);
    fill_o   = (op == SH_RA) ? msb_i : 1'b0;
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             right,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] to_left;
  logic [WIDTH-1:0] to_right;

  always_comb begin
    to_left  = {din[WIDTH-1-DIST:0], {DIST{1'b0}}};
    to_right = {{DIST{fill}}, din[WIDTH-1:DIST]};
    if (!en)
      dout = din;
    else if (right)
      dout = to_right;
    else
      dout = to_left;
  end
endmodule

// File: rtl/log_shifter.sv
module log_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);
  logic active;
  logic right;
  logic fill;
  logic [WIDTH-1:0] lvl [0:SHW];

  shift_ctl u_ctl (
    .op_i     (op_i),
    .msb_i    (opnd_i[WIDTH-1]),
    .active_o (active),
    .right_o  (right),
    .fill_o   (fill)
  );

  assign lvl[0] = opnd_i;

  // Stage k moves the word by 2**(SHW-1-k): largest distance first.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int BIT = SHW - 1 - k;
    shift_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << BIT)
    ) u_stage (
      .din   (lvl[k]),
      .en    (active & amt_i[BIT]),
      .right (right),
      .fill  (fill),
      .dout  (lvl[k+1])
    );
  end

  assign res_o = lvl[SHW];
endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [SHW-1:0]   amt_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] high_mask;
  logic             known;

  always_comb begin
    known     = !$isunknown({opnd_i, amt_i, op_i});
    low_mask  = ~({WIDTH{1'b1}} << amt_i);
    high_mask = ~({WIDTH{1'b1}} >> amt_i);
    if (known) begin
      // R1
      sll_low_zero_chk: assert (op_i != 2'b00 || (res_o & low_mask) == '0);
      // R2
      srl_high_zero_chk: assert (op_i != 2'b10 || (res_o & high_mask) == '0);
      // R3
      sra_fill_chk: assert (op_i != 2'b11 ||
        (res_o & high_mask) == (opnd_i[WIDTH-1] ? high_mask : '0));
      // R4
      pass_code_chk: assert (op_i != 2'b01 || res_o == opnd_i);
      // R5
      zero_amt_chk: assert (amt_i != '0 || res_o == opnd_i);
    end
  end
endmodule

bind log_shifter log_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_i (opnd_i),
  .amt_i  (amt_i),
  .op_i   (op_i),
  .res_o  (res_o)
);

// File: tb/log_shifter_bench.sv
module log_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic [W-1:0] opnd;
  logic [4:0]   amt;
  logic [1:0]   op;
  logic [W-1:0] res;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_shifter #(.WIDTH(W)) u_log_shifter (
    .opnd_i (opnd), .amt_i (amt), .op_i (op), .res_o (res)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input int s,
                                         input logic [1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (c)
        2'b00: r[i] = (i >= s) ? a[i-s] : 1'b0;
        2'b10: r[i] = (i + s < W) ? a[i+s] : 1'b0;
        2'b11: r[i] = (i + s < W) ? a[i+s] : a[W-1];
        default: r[i] = a[i];
      endcase
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] a, input int s, input logic [1:0] c);
    @(negedge clk);
    opnd = a; amt = s[4:0]; op = c;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%b amt=%0d opnd=%h got %h expected %h",
               req, op, amt, opnd, res, exp);
    end
  endtask

  task automatic t_idle;
    apply('0, 0, 2'b00);
    check("R5 idle zero", '0);
  endtask

  task automatic t_examples;
    apply(32'h12345678, 8, 2'b00); check("R6 left", 32'h34567800);
    apply(32'h12345678, 8, 2'b10); check("R6 right logical", 32'h00123456);
    apply(32'h12345678, 8, 2'b11); check("R6 right arith pos", 32'h00123456);
    apply(32'h92345678, 8, 2'b11); check("R6 right arith neg", 32'hFF923456);
  endtask

  task automatic t_sweep;
    logic [W-1:0] pats [4] = '{32'h12345678, 32'h92345678, 32'hFFFFFFFF, 32'h80000001};
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < W; s++) begin
        apply(pats[p], s, 2'b00); check("R1 sweep", model(pats[p], s, 2'b00));
        apply(pats[p], s, 2'b10); check("R2 sweep", model(pats[p], s, 2'b10));
        apply(pats[p], s, 2'b11); check("R3 sweep", model(pats[p], s, 2'b11));
        apply(pats[p], s, 2'b01); check("R4 sweep", pats[p]);
      end
    end
  endtask

  task automatic t_zero_amt;
    for (int c = 0; c < 4; c++) begin
      apply(32'hA5C3_0F96, 0, c[1:0]);
      check("R5 amount zero", 32'hA5C3_0F96);
    end
  endtask

  task automatic t_extremes;
    apply(32'h0000_0001, 31, 2'b00); check("R7 left max", 32'h8000_0000);
    apply(32'h7FFF_FFFE, 31, 2'b00); check("R7 left max bit0 clear", '0);
    apply(32'h8000_0000, 31, 2'b10); check("R7 right logical max", 32'h0000_0001);
    apply(32'h8000_0000, 31, 2'b11); check("R7 arith max neg", 32'hFFFF_FFFF);
    apply(32'h7FFF_FFFF, 31, 2'b11); check("R7 arith max pos", '0);
  endtask

  task automatic t_no_clock;
    @(posedge clk);
    #1;
    opnd = 32'h0000_00F0; amt = 5'd4; op = 2'b10;
    #1; check("R8 right without edge", 32'h0000_000F);
    op = 2'b00;
    #1; check("R8 left without edge", 32'h0000_0F00);
  endtask

  initial begin
    t_idle;
    t_examples;
    t_sweep;
    t_zero_amt;
    t_extremes;
    t_no_clock;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule